// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Queue

This block turns bytes written by a host into asynchronous serial frames on a single line. A write drops the byte into a holding stage. Whenever the shift stage is idle, it takes the oldest held byte and sends it as one frame: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts 16 pulses of an externally supplied 16x baud tick. Between frames the line is high.

The holding stage has two modes. With the FIFO mode input low it holds a single byte. With it high it is a 16-entry queue, so the host can load a burst and move on. Changing the mode empties the holding stage. The host paces its writes from three flags: one shows that the holding stage is empty, one shows that the shift stage is idle, and one shows that another write will be accepted. A break input forces the line low for as long as it is held. The frame timing carries on underneath, so released frames end on schedule.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset `txLine` is 1 and `holdEmpty`, `shiftEmpty` and `txReady` are all 1.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. Every bit lasts exactly 16 `baudTick` pulses. The number of data bits is 5 + `wordLen`, where `wordLen` = 0..3 gives 5..8 bits.
- R3: With `parEn` = 0 no parity bit is sent. With `parEn` = 1 one parity bit follows the data bits. Its value depends on `parSel`:
  - 00 gives odd parity over the data bits sent.
  - 01 gives even parity.
  - 10 gives a constant 1.
  - 11 gives a constant 0.
- R4: With `twoStop` = 0 the frame ends with one high stop bit. With `twoStop` = 1 it ends with two, except that 5-bit words (`wordLen` = 0) still use one stop bit.
- R5: A write places `wrData` into the holding stage, and `holdEmpty` drops in the next cycle. An idle shift stage takes the oldest held byte one cycle later and starts its frame. Bytes go out in write order, and frames run back to back.
- R6: `shiftEmpty` is 0 from the start of a frame until the last stop bit has lasted its full 16 ticks, and then returns to 1. While `shiftEmpty` is 1 and `breakCtl` is 0, the line is high.
- R7: With `fifoMode` = 0 the holding stage has one entry. `txReady` is 0 while that entry is occupied, and a write in that state is discarded.
- R8: With `fifoMode` = 1 the holding stage keeps up to 16 bytes in order. `txReady` drops when 16 are held, and further writes are discarded.
- R9: A change of `fifoMode` empties the holding stage in the following cycle. A frame already being shifted completes.
- R10: While `breakCtl` is 1, `txLine` is 0. Frame timing continues meanwhile, so a frame that overlaps a break ends at the same tick as without it.
- R11: `wordLen`, `parEn`, `parSel` and `twoStop` are captured when a frame starts. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | Host write strobe, one cycle per byte |
| wrData | input | 8 | Byte to send |
| baudTick | input | 1 | 16x baud tick, one cycle wide |
| fifoMode | input | 1 | 1: 16-entry queue, 0: single holding entry |
| wordLen | input | 2 | Data bits minus 5 |
| parEn | input | 1 | Parity bit enable |
| parSel | input | 2 | Parity kind: 00 odd, 01 even, 10 one, 11 zero |
| twoStop | input | 1 | Two stop bits (one for 5-bit words) |
| breakCtl | input | 1 | Force the line low |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding stage holds no byte |
| shiftEmpty | output | 1 | No frame in progress |
| txReady | output | 1 | A write now would be accepted |

## Verification
The hardest case to reach is a full 16-entry queue. The host has to write seventeen bytes on consecutive cycles: the first one drains into the shift stage while the remaining sixteen fill the queue. Only then does an eighteenth write show whether overflow is discarded. A mode change while bytes are still queued behind a running frame takes the same kind of back-to-back writes, followed by a mode flip before the first frame ends. For the break case, the bench counts ticks across a break placed inside the high data bits of a frame and checks that the shifter still empties on the 160th tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MIN_WORD = 5;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } parSel_e;

  typedef enum logic [2:0] {
    LN_IDLE,
    LN_START,
    LN_DATA,
    LN_PARITY,
    LN_STOP
  } lineSel_e;

  // strobes from frame control to the shift datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e sel;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_holdq.sv
module uart_tx_holdq #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              push,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pop,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              ready
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rdPtr, wrPtr;
  logic [CW-1:0]     count, cap;
  logic              modeQ, flush, doPush, doPop;

  assign cap    = fifoMode ? CW'(DEPTH) : CW'(1);
  assign flush  = (fifoMode != modeQ);
  assign empty  = (count == '0);
  assign ready  = (count < cap);
  assign doPop  = pop && !empty;
  assign doPush = push && !flush && ((count < cap) || doPop);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      modeQ <= 1'b0;
    end else begin
      modeQ <= fifoMode;
      if (flush) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (doPush) wrPtr <= wrPtr + AW'(1);
        if (doPop)  rdPtr <= rdPtr + AW'(1);
        count <= count + CW'(doPush) - CW'(doPop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned MAX_WORD      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      holdEmpty,
  input  logic [1:0] wordLen,
  input  logic      parEn,
  input  logic      twoStop,
  output txStrobe_t strb,
  output logic      shiftEmpty
);

  localparam int unsigned TW = $clog2(TICKS_PER_BIT);
  localparam int unsigned BW = $clog2(MAX_WORD);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP} state_e;

  state_e        state;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitIdx, lastBitQ;
  logic          parEnQ, twoStopQ, stopIdx;
  logic          load, bitDone;

  assign load    = (state == S_IDLE) && !holdEmpty;
  assign bitDone = (state != S_IDLE) && baudTick && (tickCnt == TW'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      lastBitQ <= '0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
      stopIdx  <= 1'b0;
    end else if (load) begin
      state    <= S_START;
      tickCnt  <= '0;
      lastBitQ <= BW'(wordLen) + BW'(MIN_WORD - 1);
      parEnQ   <= parEn;
      twoStopQ <= twoStop && (wordLen != 2'd0);
    end else if ((state != S_IDLE) && baudTick) begin
      if (!bitDone) begin
        tickCnt <= tickCnt + TW'(1);
      end else begin
        tickCnt <= '0;
        case (state)
          S_START: begin
            state  <= S_DATA;
            bitIdx <= '0;
          end
          S_DATA: begin
            if (bitIdx == lastBitQ) begin
              state   <= parEnQ ? S_PARITY : S_STOP;
              stopIdx <= 1'b0;
            end else begin
              bitIdx <= bitIdx + BW'(1);
            end
          end
          S_PARITY: begin
            state   <= S_STOP;
            stopIdx <= 1'b0;
          end
          S_STOP: begin
            if (twoStopQ && !stopIdx) stopIdx <= 1'b1;
            else                      state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb.load  = load;
    strb.shift = bitDone && (state == S_DATA);
    case (state)
      S_START:  strb.sel = LN_START;
      S_DATA:   strb.sel = LN_DATA;
      S_PARITY: strb.sel = LN_PARITY;
      S_STOP:   strb.sel = LN_STOP;
      default:  strb.sel = LN_IDLE;
    endcase
  end

  assign shiftEmpty = (state == S_IDLE);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] holdData,
  input  logic [1:0]        wordLen,
  input  logic [1:0]        parSel,
  output logic              lineBit
);

  logic [DATA_W-1:0] shReg, maskedData;
  logic              parBitQ, parNext;

  // keep only the bits that will be sent
  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      maskedData[i] = holdData[i] && (i < int'(wordLen) + int'(MIN_WORD));
    end
  end

  always_comb begin
    case (parSel_e'(parSel))
      PAR_ODD:  parNext = ~(^maskedData);
      PAR_EVEN: parNext = ^maskedData;
      PAR_MARK: parNext = 1'b1;
      default:  parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parBitQ <= 1'b0;
    end else if (strb.load) begin
      shReg   <= holdData;
      parBitQ <= parNext;
    end else if (strb.shift) begin
      shReg   <= {1'b0, shReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strb.sel)
      LN_START:  lineBit = 1'b0;
      LN_DATA:   lineBit = shReg[0];
      LN_PARITY: lineBit = parBitQ;
      default:   lineBit = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH   = 16,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic [7:0]  wrData,
  input  logic        baudTick,
  input  logic        fifoMode,
  input  logic [1:0]  wordLen,
  input  logic        parEn,
  input  logic [1:0]  parSel,
  input  logic        twoStop,
  input  logic        breakCtl,
  output logic        txLine,
  output logic        holdEmpty,
  output logic        shiftEmpty,
  output logic        txReady
);

  txStrobe_t         strb;
  logic [DATA_W-1:0] holdData;
  logic              lineBit;

  uart_tx_holdq #(.DEPTH(QUEUE_DEPTH), .DATA_W(DATA_W)) i_holdq (
    .clk      (clk),
    .rstN     (rstN),
    .fifoMode (fifoMode),
    .push     (wrStb),
    .wrData   (wrData),
    .pop      (strb.load),
    .rdData   (holdData),
    .empty    (holdEmpty),
    .ready    (txReady)
  );

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .MAX_WORD(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .holdEmpty  (holdEmpty),
    .wordLen    (wordLen),
    .parEn      (parEn),
    .twoStop    (twoStop),
    .strb       (strb),
    .shiftEmpty (shiftEmpty)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .holdData (holdData),
    .wordLen  (wordLen),
    .parSel   (parSel),
    .lineBit  (lineBit)
  );

  assign txLine = lineBit && !breakCtl;

endmodule

// File: rtl/uart_tx_serializer_chk.sv
module uart_tx_serializer_chk (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic fifoMode,
  input logic breakCtl,
  input logic txLine,
  input logic holdEmpty,
  input logic shiftEmpty,
  input logic txReady
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty && !breakCtl |-> txLine);  // R6

  AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    breakCtl |-> !txLine);  // R10

  AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) && !breakCtl |-> !txLine);  // R2

  AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rstN)
    holdEmpty |-> txReady);  // R5

  AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(wrStb));  // R5

  AST_SINGLE_SLOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !fifoMode && !holdEmpty |-> !txReady);  // R7

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode != $past(fifoMode)) |=> holdEmpty);  // R9

endmodule

bind uart_tx_serializer uart_tx_serializer_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrStb      (wrStb),
  .fifoMode   (fifoMode),
  .breakCtl   (breakCtl),
  .txLine     (txLine),
  .holdEmpty  (holdEmpty),
  .shiftEmpty (shiftEmpty),
  .txReady    (txReady)
);

// File: tb/test_uart_tx_serializer.sv
`timescale 1ns/1ps
module test_uart_tx_serializer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic       baudTick = 1'b0;
  logic       fifoMode = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       parEn = 1'b0;
  logic [1:0] parSel = 2'b00;
  logic       twoStop = 1'b0;
  logic       breakCtl = 1'b0;
  logic       txLine, holdEmpty, shiftEmpty, txReady;

  int  nChk = 0;
  int  nFail = 0;
  bit  monEn = 1'b0;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] data;
    int         nBits;
    bit         hasPar;
    bit         parVal;
    int         nStop;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  // 16x tick every fourth clock
  logic [1:0] tickDiv = '0;
  always @(posedge clk) begin
    tickDiv  <= tickDiv + 2'd1;
    baudTick <= (tickDiv == 2'd3);
  end

  uart_tx_serializer i_uart_tx_serializer (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .baudTick(baudTick),
    .fifoMode(fifoMode), .wordLen(wordLen), .parEn(parEn), .parSel(parSel),
    .twoStop(twoStop), .breakCtl(breakCtl), .txLine(txLine), .holdEmpty(holdEmpty),
    .shiftEmpty(shiftEmpty), .txReady(txReady)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the n-th tick was consumed
  task automatic waitTicks(input int n);
    int left = n;
    while (left > 0) begin
      if (baudTick) left--;
      @(negedge clk);
    end
  endtask

  function automatic expItem_t mkExp(input logic [7:0] d);
    expItem_t e;
    int ones = 0;
    e.nBits = 5 + int'(wordLen);
    e.data  = d & 8'((1 << e.nBits) - 1);
    for (int i = 0; i < 8; i++) ones += int'(e.data[i]);
    e.hasPar = parEn;
    case (parSel)
      2'b00:   e.parVal = (ones % 2 == 0);
      2'b01:   e.parVal = (ones % 2 == 1);
      2'b10:   e.parVal = 1'b1;
      default: e.parVal = 1'b0;
    endcase
    e.nStop = (twoStop && wordLen != 2'd0) ? 2 : 1;
    return e;
  endfunction

  // driver: called at a negedge, one write cycle
  task automatic sendByte(input logic [7:0] d, input bit expectIt);
    if (expectIt) expQ.push_back(mkExp(d));
    wrStb  = 1'b1;
    wrData = d;
    @(negedge clk);
    wrStb  = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    do @(negedge clk); while (!(holdEmpty && shiftEmpty));
    repeat (4) @(negedge clk);
    check(req, "frames left unsent", expQ.size(), 0);
  endtask

  // monitor: decode frames on the line and compare with the scoreboard
  initial begin : monitor
    expItem_t   e;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (monEn && rstN && txLine === 1'b0) begin
        if (expQ.size() == 0) begin
          check("R5", "unexpected frame", 1, 0);
        end else begin
          e = expQ.pop_front();
          waitTicks(8);
          check("R2", "start bit", txLine, 0);
          got = '0;
          for (int i = 0; i < e.nBits; i++) begin
            waitTicks(16);
            got[i] = txLine;
          end
          check("R2", "data bits", got, e.data);
          if (e.hasPar) begin
            waitTicks(16);
            check("R3", "parity bit", txLine, e.parVal);
          end
          for (int s = 0; s < e.nStop; s++) begin
            waitTicks(16);
            check("R4", "stop bit", txLine, 1);
          end
          waitTicks(7);
          check("R6", "late in last stop", {txLine, shiftEmpty}, 2'b10);
          waitTicks(1);
          check("R6", "shifter empty after stop", shiftEmpty, 1);
        end
      end
    end
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      report();
      $finish;
    end
  end

  initial begin : stimulus
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset flags", {txLine, holdEmpty, shiftEmpty, txReady}, 4'b1111);
    monEn = 1'b1;

    // R2 R5: 8 data bits, no parity, one stop
    sendByte(8'hA5, 1'b1);
    check("R5", "held before transfer", {holdEmpty, shiftEmpty}, 2'b01);
    @(negedge clk);
    check("R5", "moved to shifter", {holdEmpty, shiftEmpty}, 2'b10);
    waitIdle("R2");

    // R3 R7: 7 bits even parity, second byte waits, third dropped
    wordLen = 2'd2; parEn = 1'b1; parSel = 2'b01;
    sendByte(8'h3C, 1'b1);
    sendByte(8'h5A, 1'b1);
    check("R7", "single slot occupied", {holdEmpty, txReady}, 2'b00);
    sendByte(8'h77, 1'b0);
    waitIdle("R7");

    // R4: 5 bits odd parity, two stops requested, one sent
    wordLen = 2'd0; parSel = 2'b00; twoStop = 1'b1;
    sendByte(8'h1F, 1'b1);
    sendByte(8'h0B, 1'b1);
    waitIdle("R4");

    // R3 R4: 6 bits forced-one parity, two stops
    wordLen = 2'd1; parSel = 2'b10;
    sendByte(8'h2D, 1'b1);
    sendByte(8'h12, 1'b1);
    waitIdle("R3");

    // R3: 8 bits forced-zero parity
    wordLen = 2'd3; parSel = 2'b11; twoStop = 1'b0;
    sendByte(8'hFF, 1'b1);
    waitIdle("R3");

    // R8: fill the queue
    parEn = 1'b0;
    fifoMode = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 17; i++) sendByte(8'(i * 13 + 7), 1'b1);
    check("R8", "queue full", {holdEmpty, txReady}, 2'b00);
    sendByte(8'hEE, 1'b0);
    check("R8", "overflow dropped, still full", txReady, 0);
    waitIdle("R8");

    // R9: mode change empties queued bytes
    for (int i = 0; i < 4; i++) sendByte(8'(8'hC0 + i), i == 0);
    check("R9", "bytes queued", holdEmpty, 0);
    fifoMode = 1'b0;
    @(negedge clk);
    check("R9", "flushed", {holdEmpty, shiftEmpty}, 2'b10);
    waitIdle("R9");

    // R11: format change during a frame
    sendByte(8'h96, 1'b1);
    @(negedge clk);
    wordLen = 2'd0; parEn = 1'b1; twoStop = 1'b1;
    waitIdle("R11");
    wordLen = 2'd3; parEn = 1'b0; twoStop = 1'b0;

    // R10: break while idle
    monEn = 1'b0;
    repeat (4) @(negedge clk);
    breakCtl = 1'b1;
    @(negedge clk);
    check("R10", "idle break", {txLine, shiftEmpty}, 2'b01);
    breakCtl = 1'b0;
    @(negedge clk);
    check("R10", "break released", txLine, 1);

    // R10: break inside a frame, timing unchanged
    sendByte(8'hFF, 1'b0);
    @(negedge clk);
    check("R10", "frame started", shiftEmpty, 0);
    waitTicks(40);
    check("R10", "data high before break", txLine, 1);
    breakCtl = 1'b1;
    waitTicks(30);
    check("R10", "line low in break", txLine, 0);
    breakCtl = 1'b0;
    @(negedge clk);
    check("R10", "data high after break", txLine, 1);
    waitTicks(89);
    check("R10", "frame still running", shiftEmpty, 0);
    waitTicks(1);
    check("R10", "frame ends on time", shiftEmpty, 1);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule